// File: doc/BRIEF.md
# Synchronous Serial Byte Receiver

This block receives bytes over a two-wire clock-synchronous link made of one serial clock line and one serial data line. In master mode it generates the serial clock from the system clock through a programmable divider. In slave mode it takes the serial clock from outside and brings both lines into the system clock domain through two-stage synchronizers. Each bit is captured on a rising serial clock edge, most significant bit first. After eight bits, the byte moves from the shift register into a receive buffer and a full flag is raised.

A host reaches the block through a small register bus with three word locations: control, status and data. Reading the data location returns the buffered byte and drops the full flag. In master mode the clock runs without gaps, so bytes arrive back to back as long as the host reads once per byte. An overrun is flagged when the buffer is still full at the eighth rising edge of a later byte. A receive-stop control bit lets the byte in progress finish, then halts the clock and holds the line high.

Register map (2-bit word address):
- 0 = control: bit0 enable, bit1 master, bit2 receive-stop, bits 7:4 divider select.
- 1 = status: bit0 full, bit1 overrun.
- 2 = data.

Top module: `ssr_rx_top`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock and shifted in most significant bit first. The first bit of a byte becomes bit 7 of the received value.
- R2: `sclk_oe` is 1 exactly when enable (control bit0) and master (control bit1) are both set. Otherwise it is 0, and in slave mode the clock comes from `sclk_in`.
- R3: On the eighth sampled bit, the assembled byte is loaded into the receive buffer when the buffer is not full, and the full flag (status bit0) is set.
- R4: In master mode the serial clock period is (4 << s) system clocks, where s is the divider select with values above 6 treated as 6. Consecutive bytes follow each other with no idle clock, one byte every 8 periods.
- R5: Reading the data location (address 2) returns the buffer and clears the full flag on that clock edge.
- R6: If the full flag is still set when the eighth bit of a later byte is sampled, the overrun flag (status bit1) is set and the buffer keeps its earlier byte.
- R7: When receive-stop (control bit2) is set in master mode, the byte in progress completes and is loaded. The serial clock then stays high with no further rising edges until receive-stop is cleared.
- R8: While enable is 0, the master clock does not run and `sclk_out` stays high.
- R9: In slave mode, rising edges of `sclk_in` sample `sdata_in` after two-stage synchronization, and a full byte is received.
- R10: Writing status with bit1 equal to 0 clears the overrun flag. While clocking is stopped (block disabled or halted), the bit counter returns to zero, so a partial byte is discarded.
- R11: After reset, control reads 0, status reads 0, `sclk_out` is 1 and `sclk_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read clears full) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| sclk_in | input | 1 | Serial clock input used in slave mode |
| sclk_out | output | 1 | Serial clock generated in master mode, idles high |
| sclk_oe | output | 1 | Output enable for the serial clock |
| sdata_in | input | 1 | Serial data input |

## Verification
Master-mode reception uses the asymmetric bytes A5, 3C, C3 and 5A. Any error in bit order or bit offset therefore changes the received value. Arrival times of consecutive full flags are compared to show that no idle clock separates the bytes. Slave reception sends 6D, and a separate run sends three stray bits followed by 81, which shows whether disabling the block throws away a partial byte. The overrun run leaves the buffer unread and samples the status before and after the eighth bit of the next byte, so late flagging, early flagging and overwriting the buffer can each be told apart. The divider is measured at select values 2 and 9; the latter exercises the clamp.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 4;
    localparam int MAX_SEL = 6;
    localparam int DIV_W   = MAX_SEL + 2;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             spare;
        logic             rx_stop;
        logic             master;
        logic             enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2
    } addr_e;

    // Half period of the master clock in system clocks: 2 << min(sel, MAX_SEL)
    function automatic logic [DIV_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        logic [SEL_W-1:0] eff;
        eff = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        return DIV_W'(2) << eff;
    endfunction
endpackage

// File: rtl/ssr_clkgen.sv
module ssr_clkgen
    import ssr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             sclk,
    output logic             rise
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;

    assign half = half_period(div_sel);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b1;
            rise <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (cnt == half - 1'b1) begin
                cnt  <= '0;
                sclk <= !sclk;
                rise <= !sclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7
    park_high_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> sclk);

    // R1
    rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
        rise |-> (sclk && !$past(sclk)));
endmodule

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic rise,
    output logic data
);
    logic [STAGES-1:0] ck_s;
    logic [STAGES-1:0] dt_s;
    logic              ck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_s    <= '1;
            dt_s    <= '0;
            ck_prev <= 1'b1;
        end else begin
            ck_s    <= {ck_s[STAGES-2:0], sclk_in};
            dt_s    <= {dt_s[STAGES-2:0], sdata_in};
            ck_prev <= ck_s[STAGES-1];
        end
    end

    assign rise = ck_s[STAGES-1] && !ck_prev;
    assign data = dt_s[STAGES-1];

    // R9
    sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sample,
    input  logic              din,
    output logic              done,
    output logic [DATA_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;

    assign byte_val = {sh[DATA_W-2:0], din};
    assign done     = sample && (cnt == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (sample) begin
            sh  <= byte_val;
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/ssr_rx_top.sv
module ssr_rx_top
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       sclk_oe,
    input  logic       sdata_in
);
    ctrl_t             ctrl;
    logic              full, ovr, halted;
    logic [DATA_W-1:0] rbuf;

    logic master_run, slave_on, clr;
    logic m_sclk, m_rise, s_rise, s_data;
    logic sample, din, done, rd_data, full_eff;
    logic [DATA_W-1:0] byte_val;

    assign master_run = ctrl.enable && ctrl.master && !halted;
    assign slave_on   = ctrl.enable && !ctrl.master;
    assign clr        = !(master_run || slave_on);
    assign sample     = ctrl.master ? m_rise : (slave_on && s_rise);
    assign din        = ctrl.master ? sdata_in : s_data;
    assign rd_data    = bus_rd && (bus_addr == A_DATA);
    assign full_eff   = full && !rd_data;

    ssr_clkgen u_clkgen (
        .clk(clk), .rst(rst), .run(master_run), .div_sel(ctrl.div_sel),
        .sclk(m_sclk), .rise(m_rise)
    );

    ssr_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .rise(s_rise), .data(s_data)
    );

    ssr_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .clr(clr), .sample(sample), .din(din),
        .done(done), .byte_val(byte_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            full   <= 1'b0;
            ovr    <= 1'b0;
            halted <= 1'b0;
            rbuf   <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL)
                ctrl <= ctrl_t'(bus_wdata);

            if (done && full_eff)
                ovr <= 1'b1;
            else if (bus_wr && bus_addr == A_STAT && !bus_wdata[1])
                ovr <= 1'b0;

            if (done && !full_eff) begin
                full <= 1'b1;
                rbuf <= byte_val;
            end else if (rd_data) begin
                full <= 1'b0;
            end

            if (!ctrl.rx_stop)
                halted <= 1'b0;
            else if (done && ctrl.master)
                halted <= 1'b1;
        end
    end

    assign sclk_out = m_sclk;
    assign sclk_oe  = ctrl.enable && ctrl.master;

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl;
            A_STAT:  bus_rdata = {6'b0, ovr, full};
            A_DATA:  bus_rdata = rbuf;
            default: bus_rdata = '0;
        endcase
    end

    // R6
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && full && !rd_data) |=> (ovr && rbuf == $past(rbuf)));

    // R3
    full_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !full) |=> (full && rbuf == $past(byte_val)));

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done) |=> !full);

    // R7
    halt_high_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> sclk_out);

    // R8
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> sclk_out);
endmodule

// File: tb/test_ssr_rx_top.sv
module test_ssr_rx_top;
    localparam int CLK_P = 10;
    localparam logic [7:0] EN = 8'h01, MS = 8'h02, STOP = 8'h04;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0, bus_rdata;
    logic sclk_in = 1'b1, sclk_out, sclk_oe, sdata_in;
    logic slave_mode = 1'b0, s_data = 1'b0, m_data = 1'b0;
    logic [31:0] m_pat = 32'd0;
    int m_cnt = 0, m_base = 0, rises = 0;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = !clk;

    assign sdata_in = slave_mode ? s_data : m_data;

    ssr_rx_top i_ssr_rx_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdata_in(sdata_in)
    );

    always @(negedge sclk_out) begin
        m_data <= m_pat[31 - ((m_cnt - m_base) % 32)];
        m_cnt  <= m_cnt + 1;
    end

    always @(posedge sclk_out) rises <= rises + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_full(output time t);
        logic [7:0] st;
        st = 8'd0;
        for (int i = 0; i < 4000 && !st[0]; i++) bus_read(2'd1, st);
        t = $time;
    endtask

    task automatic quiesce();
        logic [7:0] d;
        bus_write(2'd0, 8'h00);
        bus_read(2'd2, d);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic start_master(input logic [31:0] pat, input logic [7:0] c);
        m_pat  = pat;
        m_base = m_cnt;
        bus_write(2'd0, c);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(2'd0, d); check(d == 8'h00, "R11 ctrl", d, 0);
        bus_read(2'd1, d); check(d == 8'h00, "R11 stat", d, 0);
        check(sclk_out == 1'b1 && sclk_oe == 1'b0, "R11 pins", {sclk_out, sclk_oe}, 2);
    endtask

    task automatic t_idle();
        int r0;
        bus_write(2'd0, MS);
        r0 = rises;
        repeat (60) @(negedge clk);
        check(rises == r0 && sclk_out, "R8 no clock while disabled", rises - r0, 0);
        check(sclk_oe == 1'b0, "R2 oe off when disabled", sclk_oe, 0);
        bus_write(2'd0, EN);
        @(negedge clk);
        check(sclk_oe == 1'b0, "R2 oe off in slave", sclk_oe, 0);
        quiesce();
    endtask

    task automatic t_master_rx();
        time t1, t2;
        logic [7:0] d;
        start_master(32'hA53CF00F, EN | MS);
        @(negedge clk);
        check(sclk_oe == 1'b1, "R2 oe on in master", sclk_oe, 1);
        wait_full(t1);
        bus_read(2'd2, d); check(d == 8'hA5, "R1 R3 first byte", d, 8'hA5);
        bus_read(2'd1, d); check(d[0] == 1'b0, "R5 read clears full", d, 0);
        wait_full(t2);
        check((t2 - t1) / CLK_P == 32, "R4 back-to-back bytes", int'((t2 - t1) / CLK_P), 32);
        bus_read(2'd2, d); check(d == 8'h3C, "R1 second byte", d, 8'h3C);
        quiesce();
    endtask

    task automatic t_period(input logic [3:0] sel, input int exp);
        time t0, t1;
        start_master(32'h0, EN | MS | {sel, 4'h0});
        @(posedge sclk_out); t0 = $time;
        repeat (2) @(posedge sclk_out); t1 = $time;
        check((t1 - t0) / CLK_P == 2 * exp, "R4 divider period", int'((t1 - t0) / CLK_P), 2 * exp);
        quiesce();
    endtask

    task automatic t_overrun();
        time t;
        logic [7:0] d;
        start_master(32'h11223344, EN | MS);
        wait_full(t);
        repeat (16) @(negedge clk);
        bus_read(2'd1, d); check(d[1] == 1'b0, "R6 no overrun before 8th bit", d, 1);
        repeat (20) @(negedge clk);
        bus_read(2'd1, d); check(d[1] == 1'b1, "R6 overrun set", d, 3);
        bus_read(2'd2, d); check(d == 8'h11, "R6 buffer keeps old byte", d, 8'h11);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d); check(d[1] == 1'b0, "R10 overrun cleared by write", d, 0);
        quiesce();
    endtask

    task automatic t_stop();
        time t;
        int r0;
        logic [7:0] d;
        start_master(32'hC35A9966, EN | MS);
        wait_full(t);
        bus_read(2'd2, d); check(d == 8'hC3, "R7 byte before stop", d, 8'hC3);
        bus_write(2'd0, EN | MS | STOP);
        wait_full(t);
        bus_read(2'd2, d); check(d == 8'h5A, "R7 byte in progress completes", d, 8'h5A);
        r0 = rises;
        repeat (100) @(negedge clk);
        check(rises == r0 && sclk_out, "R7 clock parked high", rises - r0, 0);
        bus_read(2'd1, d); check(d[0] == 1'b0, "R7 no further byte", d, 0);
        quiesce();
    endtask

    task automatic send_bits(input int n, input logic [7:0] v);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk); sclk_in = 1'b0; s_data = v[i];
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_slave();
        logic [7:0] d;
        slave_mode = 1'b1;
        bus_write(2'd0, EN);
        send_bits(8, 8'h6D);
        repeat (4) @(negedge clk);
        bus_read(2'd1, d); check(d[0] == 1'b1, "R9 slave full", d, 1);
        bus_read(2'd2, d); check(d == 8'h6D, "R9 slave byte", d, 8'h6D);
        send_bits(3, 8'hE0);
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, EN);
        send_bits(8, 8'h81);
        repeat (4) @(negedge clk);
        bus_read(2'd2, d); check(d == 8'h81, "R10 partial byte discarded", d, 8'h81);
        quiesce();
        slave_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_master_rx();
        t_period(4'd2, 16);
        t_period(4'd9, 256);
        t_overrun();
        t_stop();
        t_slave();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule